// File: doc/BRIEF.md
# Register Window Spill/Fill Engine

This block copies a run of 128-bit architectural registers between a register file and a procedure stack held in memory. Each register is handled as two 64-bit halves. The low half carries an 8-bit tag. The block moves one 64-bit word per clock over a single memory port, and a byte-wide tag port runs beside it. A spill reads registers and writes them upward from the current stack index. A fill reads words back downward and writes them into the register file, so that it mirrors the spill exactly. The block owns the stack index. It checks the stack bounds before any access and reports an error pulse when a request is refused.

Every register takes a 16-byte slot on the stack, whether or not its high half is moved. The layout select input picks one of two placements. In the per-register layout each slot holds its own two halves. In the paired layout two neighbouring registers share a 32-byte group, with both low halves first and both high halves after them. The extended flag chooses whether high halves are moved at all.

Top module: `regwin_xfer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bounds_err`, `arg_err`, `mem_en`, `rf_we_lo` and `rf_we_hi` are low and `stk_index` is 0.
- R2: A frame of n registers is n*16 bytes. A completed spill adds n*16 to `stk_index` and a completed fill subtracts n*16, also when high halves are not moved.
- R3: With `legacy_layout`=0, register r (0-based within the request) has its low half at byte offset 16r and its high half at 16r+8 from the frame base. Byte k of a 64-bit data word sits at word address + k.
- R4: With `legacy_layout`=1, registers 2g and 2g+1 fill the 32-byte group at offset 32g. The words in that group are: low of 2g at +0, low of 2g+1 at +8, high of 2g at +16, high of 2g+1 at +24.
- R5: High halves are moved only when `req_wide`=1. Otherwise their stack words stay unchanged on a spill, and the register high halves stay unchanged on a fill.
- R6: Every word written also writes the tag byte at `tag_base` + (byte offset / 8). A low half stores its register tag and a high half stores 0. On a fill the low half's tag byte is restored into the register tag, and the high half's tag is not used.
- R7: A spill with `stk_index` + n*16 > `stk_size` is refused with a one-cycle `bounds_err` and `done`. No access is made and the index is unchanged. Equality is allowed.
- R8: A fill with `stk_index` < n*16 is refused in the same way. Equality is allowed and leaves the index at 0.
- R9: One word access per cycle. Spill addresses rise strictly and fill addresses fall strictly. Fill issues the highest-numbered register (or pair) first. Each read's data is written to the register file in the cycle after the read.
- R10: Take the start edge as edge 0 and let N be the word count (2n if wide, else n). `done` pulses for one cycle after edge N for a spill and after edge N+1 for a fill. `stk_index` changes only in the `done` cycle of a transfer.
- R11: `req_start` is ignored while `busy` is high.
- R12: An odd count in the paired layout, or a count above the register file size, is refused with a one-cycle `arg_err` and `done` and no access. This check wins over the bounds checks.
- R13: A count of 0 completes with `done` right after the start edge, makes no access and leaves the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start request, sampled while idle |
| req_fill | input | 1 | 0 = spill, 1 = fill |
| req_cnt | input | CNT_W | Register count |
| req_wide | input | 1 | Move high halves too |
| legacy_layout | input | 1 | 1 = paired 32-byte group layout |
| stk_base | input | ADDR_W | Byte address of stack index 0 |
| tag_base | input | ADDR_W | Byte address of the tag region |
| stk_size | input | IDX_W | Stack size in bytes |
| stk_index | output | IDX_W | Current stack index in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| bounds_err | output | 1 | Stack-bounds refusal, with done |
| arg_err | output | 1 | Bad count refusal, with done |
| mem_en | output | 1 | Word access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 64 | Write data, little-endian |
| mem_rdata | input | 64 | Read data, one cycle after the read |
| tag_we | output | 1 | Tag byte write |
| tag_addr | output | ADDR_W | Tag byte address, shares mem_en for reads |
| tag_wdata | output | 8 | Tag write byte |
| tag_rdata | input | 8 | Tag read byte, one cycle after the read |
| rf_raddr | output | RA_W | Register read select |
| rf_rdata_lo | input | 64 | Low half, combinational read |
| rf_rdata_hi | input | 64 | High half, combinational read |
| rf_rtag | input | 8 | Low half tag |
| rf_waddr | output | RA_W | Register write select |
| rf_we_lo | output | 1 | Write low half and tag |
| rf_we_hi | output | 1 | Write high half |
| rf_wdata | output | 64 | Register write data |
| rf_wtag | output | 8 | Register write tag |

## Verification
Take the start edge as edge 0. A refusal or a zero count shows `done` at once after that edge. A spill of N words finishes after edge N, and a fill finishes one edge later because of the read-data stage. Stack index updates coincide with `done`. The bench drives every request on a falling edge and counts falling edges until `done`. It compares that count with N or N+1, computed from the count and the wide flag. Memory contents, tag bytes and register halves are checked only once the transfer is done, against slot offsets computed arithmetically in the bench.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned SLOT_BYTES = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic fill;
        logic wide;
        logic legacy;
    } xfer_mode_t;

endpackage

// File: rtl/regwin_seq.sv
// Word walker: holds the current word index within the frame and maps it to
// a register number and half for either layout.
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int RA_W  = 6,
    parameter int WC_W  = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  xfer_mode_t       mode_in,
    input  logic [CNT_W-1:0] cnt,
    output logic [RA_W-1:0]  reg_sel,
    output logic             hi_sel,
    output logic [WC_W-1:0]  word_idx,
    output logic             last
);

    xfer_mode_t      mode_q;
    logic [WC_W-1:0] w_q, rem_q;
    logic [WC_W-1:0] n2, first_w, n_acc, stride, step_w;

    assign n2 = {cnt, 1'b0};

    // starting word and number of accesses for a new request
    always_comb begin
        if (!mode_in.fill)
            first_w = '0;
        else if (mode_in.wide)
            first_w = n2 - WC_W'(1);
        else if (mode_in.legacy)
            first_w = n2 - WC_W'(3);
        else
            first_w = n2 - WC_W'(2);
        n_acc = mode_in.wide ? n2 : WC_W'(cnt);
    end

    // distance to the next word, skipping high halves when narrow
    always_comb begin
        if (mode_q.wide)
            stride = WC_W'(1);
        else if (!mode_q.legacy)
            stride = WC_W'(2);
        else if (mode_q.fill)
            stride = w_q[0] ? WC_W'(1) : WC_W'(3);
        else
            stride = w_q[0] ? WC_W'(3) : WC_W'(1);
        step_w = mode_q.fill ? (w_q - stride) : (w_q + stride);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q    <= '0;
            rem_q  <= '0;
            mode_q <= '0;
        end else if (load) begin
            w_q    <= first_w;
            rem_q  <= n_acc;
            mode_q <= mode_in;
        end else if (adv) begin
            w_q    <= step_w;
            rem_q  <= rem_q - WC_W'(1);
        end
    end

    assign reg_sel  = mode_q.legacy ? {w_q[RA_W:2], w_q[0]} : w_q[RA_W:1];
    assign hi_sel   = mode_q.legacy ? w_q[1] : w_q[0];
    assign word_idx = w_q;
    assign last     = (rem_q == WC_W'(1));

endmodule

// File: rtl/regwin_guard.sv
// Request screening: count legality and stack room, computed wide enough
// that no sum wraps.
module regwin_guard #(
    parameter int NREG  = 64,
    parameter int IDX_W = 20,
    parameter int CNT_W = 7
) (
    input  logic             fill,
    input  logic             legacy,
    input  logic [CNT_W-1:0] cnt,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] size,
    output logic             arg_bad,
    output logic             room_bad,
    output logic [IDX_W-1:0] frame_bytes
);

    localparam int SUM_W = IDX_W + CNT_W + 5;

    logic [SUM_W-1:0] frame_w, idx_w, size_w;

    assign frame_w = SUM_W'({cnt, 4'b0000});
    assign idx_w   = SUM_W'(idx);
    assign size_w  = SUM_W'(size);

    assign arg_bad     = (legacy && cnt[0]) || (cnt > CNT_W'(NREG));
    assign room_bad    = fill ? (idx_w < frame_w) : ((idx_w + frame_w) > size_w);
    assign frame_bytes = IDX_W'(frame_w);

endmodule

// File: rtl/regwin_wb.sv
// Fill write-back stage: remembers which register half a read belongs to and
// writes the returned word one cycle later.
module regwin_wb #(
    parameter int RA_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic [RA_W-1:0] cap_reg,
    input  logic            cap_hi,
    input  logic [63:0]     mem_rdata,
    input  logic [7:0]      tag_rdata,
    output logic [RA_W-1:0] rf_waddr,
    output logic            rf_we_lo,
    output logic            rf_we_hi,
    output logic [63:0]     rf_wdata,
    output logic [7:0]      rf_wtag
);

    logic            pend_v, pend_hi;
    logic [RA_W-1:0] pend_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_hi  <= 1'b0;
            pend_reg <= '0;
        end else begin
            pend_v   <= cap;
            pend_hi  <= cap_hi;
            pend_reg <= cap_reg;
        end
    end

    assign rf_waddr = pend_reg;
    assign rf_we_lo = pend_v && !pend_hi;
    assign rf_we_hi = pend_v && pend_hi;
    assign rf_wdata = mem_rdata;
    assign rf_wtag  = tag_rdata;

endmodule

// File: rtl/regwin_xfer.sv
module regwin_xfer
    import regwin_pkg::*;
#(
    parameter  int NREG   = 64,
    parameter  int IDX_W  = 20,
    parameter  int ADDR_W = 32,
    localparam int RA_W   = $clog2(NREG),
    localparam int CNT_W  = RA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_fill,
    input  logic [CNT_W-1:0]  req_cnt,
    input  logic              req_wide,
    input  logic              legacy_layout,
    input  logic [ADDR_W-1:0] stk_base,
    input  logic [ADDR_W-1:0] tag_base,
    input  logic [IDX_W-1:0]  stk_size,
    output logic [IDX_W-1:0]  stk_index,
    output logic              busy,
    output logic              done,
    output logic              bounds_err,
    output logic              arg_err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              tag_we,
    output logic [ADDR_W-1:0] tag_addr,
    output logic [7:0]        tag_wdata,
    input  logic [7:0]        tag_rdata,
    output logic [RA_W-1:0]   rf_raddr,
    input  logic [63:0]       rf_rdata_lo,
    input  logic [63:0]       rf_rdata_hi,
    input  logic [7:0]        rf_rtag,
    output logic [RA_W-1:0]   rf_waddr,
    output logic              rf_we_lo,
    output logic              rf_we_hi,
    output logic [63:0]       rf_wdata,
    output logic [7:0]        rf_wtag
);

    localparam int WC_W = CNT_W + 1;

    xfer_state_e      st_q;
    logic             fill_q;
    logic [IDX_W-1:0] idx_q, base_q, fin_q;
    logic             done_q, berr_q, aerr_q;

    logic             arg_bad, room_bad;
    logic [IDX_W-1:0] frame;
    xfer_mode_t       mode_in;
    logic             accept, issue;
    logic [RA_W-1:0]  seq_reg;
    logic             seq_hi, seq_last;
    logic [WC_W-1:0]  seq_word;
    logic [IDX_W-1:0] off;

    assign mode_in = '{fill: req_fill, wide: req_wide, legacy: legacy_layout};

    regwin_guard #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_guard (
        .fill        (req_fill),
        .legacy      (legacy_layout),
        .cnt         (req_cnt),
        .idx         (idx_q),
        .size        (stk_size),
        .arg_bad     (arg_bad),
        .room_bad    (room_bad),
        .frame_bytes (frame)
    );

    assign accept = (st_q == ST_IDLE) && req_start && !arg_bad && !room_bad
                    && (req_cnt != '0);
    assign issue  = (st_q == ST_RUN);

    regwin_seq #(.CNT_W(CNT_W), .RA_W(RA_W), .WC_W(WC_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .adv      (issue),
        .mode_in  (mode_in),
        .cnt      (req_cnt),
        .reg_sel  (seq_reg),
        .hi_sel   (seq_hi),
        .word_idx (seq_word),
        .last     (seq_last)
    );

    regwin_wb #(.RA_W(RA_W)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .cap       (issue && fill_q),
        .cap_reg   (seq_reg),
        .cap_hi    (seq_hi),
        .mem_rdata (mem_rdata),
        .tag_rdata (tag_rdata),
        .rf_waddr  (rf_waddr),
        .rf_we_lo  (rf_we_lo),
        .rf_we_hi  (rf_we_hi),
        .rf_wdata  (rf_wdata),
        .rf_wtag   (rf_wtag)
    );

    // byte offset of the current word from stack index 0
    assign off = base_q + IDX_W'({seq_word, 3'b000});

    assign mem_en    = issue;
    assign mem_we    = issue && !fill_q;
    assign mem_addr  = stk_base + ADDR_W'(off);
    assign mem_wdata = seq_hi ? rf_rdata_hi : rf_rdata_lo;
    assign tag_we    = issue && !fill_q;
    assign tag_addr  = tag_base + ADDR_W'(off >> 3);
    assign tag_wdata = seq_hi ? 8'h00 : rf_rtag;
    assign rf_raddr  = seq_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            fill_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            fin_q  <= '0;
            done_q <= 1'b0;
            berr_q <= 1'b0;
            aerr_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            berr_q <= 1'b0;
            aerr_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_start) begin
                        if (arg_bad) begin
                            aerr_q <= 1'b1;
                            done_q <= 1'b1;
                        end else if (room_bad) begin
                            berr_q <= 1'b1;
                            done_q <= 1'b1;
                        end else if (req_cnt == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q   <= ST_RUN;
                            fill_q <= req_fill;
                            base_q <= req_fill ? (idx_q - frame) : idx_q;
                            fin_q  <= req_fill ? (idx_q - frame) : (idx_q + frame);
                        end
                    end
                end
                ST_RUN: begin
                    if (seq_last) begin
                        if (fill_q) begin
                            st_q <= ST_DRAIN;
                        end else begin
                            st_q   <= ST_IDLE;
                            idx_q  <= fin_q;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    st_q   <= ST_IDLE;
                    idx_q  <= fin_q;
                    done_q <= 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign stk_index  = idx_q;
    assign busy       = (st_q != ST_IDLE);
    assign done       = done_q;
    assign bounds_err = berr_q;
    assign arg_err    = aerr_q;

endmodule

// File: rtl/regwin_xfer_chk.sv
module regwin_xfer_chk #(
    parameter int IDX_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             bounds_err,
    input logic             arg_err,
    input logic             mem_en,
    input logic             mem_we,
    input logic             rf_we_lo,
    input logic             rf_we_hi,
    input logic [IDX_W-1:0] stk_index
);

    assert_access_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    assert_wb_after_read_R9: assert property (@(posedge clk) disable iff (rst)
        (rf_we_lo || rf_we_hi) |-> $past(mem_en && !mem_we));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_index_only_at_done_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(stk_index));

    assert_bounds_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        bounds_err |-> (done && !busy));

    assert_arg_excl_R12: assert property (@(posedge clk) disable iff (rst)
        arg_err |-> (done && !bounds_err && !busy));

    assert_one_half_R5: assert property (@(posedge clk) disable iff (rst)
        !(rf_we_lo && rf_we_hi));

endmodule

bind regwin_xfer regwin_xfer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .bounds_err (bounds_err),
    .arg_err    (arg_err),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .rf_we_lo   (rf_we_lo),
    .rf_we_hi   (rf_we_hi),
    .stk_index  (stk_index)
);

// File: tb/regwin_xfer_test.sv
`timescale 1ns/1ps
module regwin_xfer_test;

    localparam int NREG   = 8;
    localparam int IDX_W  = 12;
    localparam int ADDR_W = 16;
    localparam int RA_W   = $clog2(NREG);
    localparam int CNT_W  = RA_W + 1;
    localparam logic [15:0] STK_BASE = 16'h1000;
    localparam logic [15:0] TAG_BASE = 16'h0200;
    localparam logic [63:0] SENT     = 64'hDEAD_BEEF_0000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_start = 1'b0, req_fill = 1'b0, req_wide = 1'b0, legacy_layout = 1'b0;
    logic [CNT_W-1:0]  req_cnt = '0;
    logic [IDX_W-1:0]  stk_size = 12'd512;
    logic [IDX_W-1:0]  stk_index;
    logic              busy, done, bounds_err, arg_err;
    logic              mem_en, mem_we, tag_we, rf_we_lo, rf_we_hi;
    logic [ADDR_W-1:0] mem_addr, tag_addr;
    logic [63:0]       mem_wdata, mem_rdata, rf_rdata_lo, rf_rdata_hi, rf_wdata;
    logic [7:0]        tag_wdata, tag_rdata, rf_rtag, rf_wtag;
    logic [RA_W-1:0]   rf_raddr, rf_waddr;

    logic [63:0] mem  [64];
    logic [7:0]  tmem [64];
    logic [63:0] rlo  [NREG];
    logic [63:0] rhi  [NREG];
    logic [7:0]  rtg  [NREG];

    int checks = 0, errors = 0;
    int acc_cnt = 0, order_bad = 0;
    logic have_prev = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;

    always #2 clk = ~clk;

    regwin_xfer #(.NREG(NREG), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_fill(req_fill),
        .req_cnt(req_cnt), .req_wide(req_wide), .legacy_layout(legacy_layout),
        .stk_base(STK_BASE), .tag_base(TAG_BASE), .stk_size(stk_size),
        .stk_index(stk_index), .busy(busy), .done(done), .bounds_err(bounds_err),
        .arg_err(arg_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tag_we(tag_we),
        .tag_addr(tag_addr), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
        .rf_raddr(rf_raddr), .rf_rdata_lo(rf_rdata_lo), .rf_rdata_hi(rf_rdata_hi),
        .rf_rtag(rf_rtag), .rf_waddr(rf_waddr), .rf_we_lo(rf_we_lo),
        .rf_we_hi(rf_we_hi), .rf_wdata(rf_wdata), .rf_wtag(rf_wtag)
    );

    assign rf_rdata_lo = rlo[rf_raddr];
    assign rf_rdata_hi = rhi[rf_raddr];
    assign rf_rtag     = rtg[rf_raddr];

    // memory, tag store and register file models
    always @(posedge clk) begin
        if (mem_en) begin
            acc_cnt <= acc_cnt + 1;
            if (have_prev && (mem_we ? (mem_addr <= prev_addr) : (mem_addr >= prev_addr)))
                order_bad <= order_bad + 1;
            have_prev <= 1'b1;
            prev_addr <= mem_addr;
            if (mem_we) begin
                mem[6'((mem_addr - STK_BASE) >> 3)] <= mem_wdata;
                if (tag_we) tmem[6'(tag_addr - TAG_BASE)] <= tag_wdata;
            end else begin
                mem_rdata <= mem[6'((mem_addr - STK_BASE) >> 3)];
                tag_rdata <= tmem[6'(tag_addr - TAG_BASE)];
            end
        end
        if (rf_we_lo) begin
            rlo[rf_waddr] <= rf_wdata;
            rtg[rf_waddr] <= rf_wtag;
        end
        if (rf_we_hi) rhi[rf_waddr] <= rf_wdata;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int r, input int salt);
        return 64'h0123_4567_89AB_CDEF ^ (64'(salt) << 16) ^ 64'(r);
    endfunction

    task automatic preset_mem();
        for (int k = 0; k < 64; k++) begin
            mem[k]  = SENT | 64'(k);
            tmem[k] = 8'hEE;
        end
    endtask

    task automatic do_op(input logic fill, input int n, input logic wide, input logic leg,
                         output int lat, output logic be, output logic ae);
        @(negedge clk);
        req_fill = fill; req_cnt = CNT_W'(n); req_wide = wide; legacy_layout = leg;
        req_start = 1'b1; acc_cnt = 0; order_bad = 0; have_prev = 1'b0;
        @(negedge clk);
        req_start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        be = bounds_err;
        ae = arg_err;
    endtask

    // byte offsets of a register's halves from the frame base
    function automatic int lo_off(input int r, input logic leg);
        return leg ? (32 * (r / 2) + 8 * (r % 2)) : 16 * r;
    endfunction
    function automatic int hi_off(input int r, input logic leg);
        return leg ? (32 * (r / 2) + 16 + 8 * (r % 2)) : 16 * r + 8;
    endfunction

    task automatic sweep_case(input int n, input logic wide, input logic leg);
        int lat, nw, salt, lw, hw;
        logic be, ae;
        string lay;
        nw   = wide ? 2 * n : n;
        salt = n + 16 * int'(wide) + 32 * int'(leg);
        lay  = leg ? "R4" : "R3";
        preset_mem();
        for (int r = 0; r < NREG; r++) begin
            rlo[r] = pat(r, salt);
            rhi[r] = ~pat(r, salt + 100);
            rtg[r] = 8'(r * 7 + salt + 1);
        end
        do_op(1'b0, n, wide, leg, lat, be, ae);
        chk("R10", "spill latency", 64'(lat), 64'(nw));
        chk("R7", "spill no error", {62'd0, be, ae}, 64'd0);
        chk("R2", "spill index", 64'(stk_index), 64'(32 + 16 * n));
        chk("R9", "spill ascending", 64'(order_bad), 64'd0);
        chk("R9", "spill access count", 64'(acc_cnt), 64'(nw));
        for (int r = 0; r < n; r++) begin
            lw = (32 + lo_off(r, leg)) / 8;
            hw = (32 + hi_off(r, leg)) / 8;
            chk(lay, "low half word", mem[lw], pat(r, salt));
            chk("R6", "low tag", 64'(tmem[lw]), 64'(8'(r * 7 + salt + 1)));
            if (wide) begin
                chk(lay, "high half word", mem[hw], ~pat(r, salt + 100));
                chk("R6", "high tag zero", 64'(tmem[hw]), 64'd0);
            end else begin
                chk("R5", "high word untouched", mem[hw], SENT | 64'(hw));
                chk("R5", "high tag untouched", 64'(tmem[hw]), 64'hEE);
            end
        end
        for (int r = 0; r < NREG; r++) begin
            rlo[r] = 64'h5A5A_0000_0000_0000 | 64'(r);
            rhi[r] = 64'hA5A5_0000_0000_0000 | 64'(r);
            rtg[r] = 8'h33;
        end
        do_op(1'b1, n, wide, leg, lat, be, ae);
        chk("R10", "fill latency", 64'(lat), 64'(nw + 1));
        chk("R2", "fill index", 64'(stk_index), 64'd32);
        chk("R9", "fill descending", 64'(order_bad), 64'd0);
        chk("R9", "fill access count", 64'(acc_cnt), 64'(nw));
        for (int r = 0; r < n; r++) begin
            chk(lay, "fill low half", rlo[r], pat(r, salt));
            chk("R6", "fill tag", 64'(rtg[r]), 64'(8'(r * 7 + salt + 1)));
            chk("R5", "fill high half", rhi[r],
                wide ? ~pat(r, salt + 100) : (64'hA5A5_0000_0000_0000 | 64'(r)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat, dcount;
        logic be, ae;
        for (int r = 0; r < NREG; r++) begin
            rlo[r] = '0; rhi[r] = '0; rtg[r] = '0;
        end
        mem_rdata = '0; tag_rdata = '0;
        preset_mem();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk("R1", "reset idle", {59'd0, busy, done, bounds_err, arg_err, mem_en}, 64'd0);
        chk("R1", "reset rf writes", {62'd0, rf_we_lo, rf_we_hi}, 64'd0);
        chk("R1", "reset index", 64'(stk_index), 64'd0);

        do_op(1'b0, 2, 1'b1, 1'b0, lat, be, ae);
        chk("R2", "first spill index", 64'(stk_index), 64'd32);

        for (int leg = 0; leg < 2; leg++)
            for (int wd = 0; wd < 2; wd++)
                for (int n = 1; n <= NREG; n++)
                    if (leg == 0 || n % 2 == 0)
                        sweep_case(n, wd[0], leg[0]);

        // R13: empty request
        do_op(1'b0, 0, 1'b1, 1'b0, lat, be, ae);
        chk("R13", "zero count latency", 64'(lat), 64'd0);
        chk("R13", "zero count accesses", 64'(acc_cnt), 64'd0);
        chk("R13", "zero count index", 64'(stk_index), 64'd32);

        // R7: spill room, one byte short then exact
        stk_size = 12'd159;
        do_op(1'b0, 8, 1'b1, 1'b0, lat, be, ae);
        chk("R7", "spill overflow flags", {62'd0, be, ae}, 64'd2);
        chk("R7", "spill overflow latency", 64'(lat), 64'd0);
        chk("R7", "spill overflow accesses", 64'(acc_cnt), 64'd0);
        chk("R7", "spill overflow index", 64'(stk_index), 64'd32);
        stk_size = 12'd160;
        do_op(1'b0, 8, 1'b0, 1'b0, lat, be, ae);
        chk("R7", "spill exact fit flag", 64'(be), 64'd0);
        chk("R7", "spill exact fit index", 64'(stk_index), 64'd160);
        do_op(1'b1, 8, 1'b0, 1'b0, lat, be, ae);
        chk("R2", "fill back index", 64'(stk_index), 64'd32);
        stk_size = 12'd512;

        // R8: fill underflow then exact
        do_op(1'b1, 3, 1'b1, 1'b0, lat, be, ae);
        chk("R8", "fill underflow flags", {62'd0, be, ae}, 64'd2);
        chk("R8", "fill underflow accesses", 64'(acc_cnt), 64'd0);
        chk("R8", "fill underflow index", 64'(stk_index), 64'd32);
        do_op(1'b1, 2, 1'b0, 1'b0, lat, be, ae);
        chk("R8", "fill exact flag", 64'(be), 64'd0);
        chk("R8", "fill exact index", 64'(stk_index), 64'd0);
        chk("R10", "fill exact latency", 64'(lat), 64'd3);
        do_op(1'b0, 2, 1'b1, 1'b0, lat, be, ae);
        chk("R2", "respill index", 64'(stk_index), 64'd32);

        // R12: bad counts
        do_op(1'b0, 3, 1'b1, 1'b1, lat, be, ae);
        chk("R12", "odd paired flags", {62'd0, be, ae}, 64'd1);
        chk("R12", "odd paired accesses", 64'(acc_cnt), 64'd0);
        chk("R12", "odd paired index", 64'(stk_index), 64'd32);
        do_op(1'b0, 9, 1'b0, 1'b0, lat, be, ae);
        chk("R12", "oversize flags", {62'd0, be, ae}, 64'd1);
        do_op(1'b1, 3, 1'b0, 1'b1, lat, be, ae);
        chk("R12", "arg over bounds priority", {62'd0, be, ae}, 64'd1);
        chk("R12", "priority latency", 64'(lat), 64'd0);

        // R11: start while busy
        @(negedge clk);
        req_fill = 1'b0; req_cnt = CNT_W'(4); req_wide = 1'b1; legacy_layout = 1'b0;
        req_start = 1'b1; acc_cnt = 0; order_bad = 0; have_prev = 1'b0;
        @(negedge clk);
        req_start = 1'b0;
        lat = 0;
        @(negedge clk); lat++;
        req_fill = 1'b1; req_cnt = CNT_W'(1); req_start = 1'b1;
        @(negedge clk); lat++;
        req_start = 1'b0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R11", "busy start latency", 64'(lat), 64'd8);
        chk("R11", "busy start index", 64'(stk_index), 64'd96);
        chk("R11", "busy start accesses", 64'(acc_cnt), 64'd8);
        dcount = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done) dcount++;
        end
        chk("R11", "no second done", 64'(dcount), 64'd0);
        do_op(1'b1, 4, 1'b1, 1'b0, lat, be, ae);
        chk("R2", "busy case fill back", 64'(stk_index), 64'd32);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule